// File: doc/BRIEF.md
# Two-Pass Backward-Metric Checkpoint Sequencer

This block drives the control side of an exact two-pass soft-decision trellis decoder over a block of N positions. It generates no metric arithmetic. Each cycle it tells the datapath which trellis position to work on, in which direction, and which memory to touch.

In the first pass it walks the whole block from the last position down to position zero. It raises a checkpoint write strobe at every position that is a multiple of 64. This saves the eight backward state metrics there.

In the second pass it visits the 64-position sub-blocks in ascending order. For every sub-block except the last, it first restores the saved metrics at the sub-block's upper boundary. It then sweeps backwards, filling a 64-entry local buffer, and then sweeps forwards, reading that buffer and strobing an output write on each position.

The last sub-block may be shorter than 64. It is processed with its true length, and its backward sweep starts from the known all-zero-state initialisation at position N instead of a checkpoint. The forward recursion starts from the known state at position 0. Because sub-blocks run in ascending order, the forward state carries across sub-block edges.

Top module: `beta_ckpt_seq`

## Requirements
- R1: After reset, and whenever idle, phase_o is 0 and busy_o, done_o and every strobe are 0. step_idx_o, ckpt_addr_o and lbuf_addr_o are also 0.
- R2: A start_i sampled in idle with blk_len_i of 1 to 32767 latches N, and pass 1 begins on the next cycle. A start_i with blk_len_i of 0 is ignored. So are start_i and any blk_len_i change while a run is in progress.
- R3: Pass 1 (phase_o 1) issues one backward step per cycle, with step_valid_o and bwd_o high, for step_idx_o = N-1 down to 0. init_o is high only on the step at N-1.
- R4: During pass 1, ckpt_wr_o is high exactly on steps whose index k is a multiple of 64. ckpt_addr_o carries k/64 on every pass-1 step.
- R5: Pass 2 visits sub-block j = 0, 1, ... in ascending order, covering positions 64j up to min(64j+64, N)-1. Every sub-block except the last begins with one load cycle (phase_o 2). On that cycle ckpt_rd_o is high, ckpt_addr_o is j+1, step_idx_o is 64j+64, and step_valid_o is low.
- R6: The last sub-block has no load cycle. Its backward sweep starts at N-1 with init_o high on that first step.
- R7: The backward sweep (phase_o 3) steps from the sub-block's top position down to 64j with bwd_o and lbuf_wr_o high, and lbuf_addr_o = k mod 64. A partial last sub-block takes exactly N mod 64 steps.
- R8: The forward sweep (phase_o 4) steps from 64j upward with lbuf_rd_o and out_wr_o high, bwd_o low and lbuf_addr_o = k mod 64. init_o is high only at position 0.
- R9: The cycle after the last forward step, done_o is high for exactly one cycle with phase_o 5 and busy_o low, and the block is then idle. A run thus lasts 3N + ceil(N/64) - 1 step cycles.
- R10: busy_o is high exactly in phases 1 to 4, and out_wr_o is never high outside phase 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start request, honoured only in idle |
| blk_len_i | input | 15 | Block length N |
| phase_o | output | 3 | 0 idle, 1 pass 1, 2 load, 3 backward, 4 forward, 5 done |
| busy_o | output | 1 | A run is in progress |
| done_o | output | 1 | One-cycle completion pulse |
| step_valid_o | output | 1 | A trellis step is issued this cycle |
| step_idx_o | output | 15 | Trellis position (boundary position on a load cycle) |
| bwd_o | output | 1 | Step is a backward recursion |
| init_o | output | 1 | Step starts from the known all-zero state |
| ckpt_wr_o | output | 1 | Save backward metrics to checkpoint store |
| ckpt_rd_o | output | 1 | Restore backward metrics from checkpoint store |
| ckpt_addr_o | output | 9 | Checkpoint store index |
| lbuf_wr_o | output | 1 | Write local sub-block buffer |
| lbuf_rd_o | output | 1 | Read local sub-block buffer |
| lbuf_addr_o | output | 6 | Local buffer index |
| out_wr_o | output | 1 | Write output value for step_idx_o |

## Verification
The hardest cases are the sub-block seams. These include a block length that lands exactly on a multiple of 64, one just past it (leaving a one-position last sub-block), and one just below it. In those cases load cycles, skipped loads and true-length sweeps meet.

The stimulus sweeps every length from 1 to 200, plus a few long blocks, and compares every output on every cycle against a sequence built arithmetically from N. On some runs, start_i and blk_len_i are also toggled during pass 1 to show they are ignored.

// File: rtl/beta_ckpt_pkg.sv
package beta_ckpt_pkg;
  typedef enum logic [2:0] {
    PH_IDLE = 3'd0,
    PH_FILL = 3'd1,
    PH_LOAD = 3'd2,
    PH_BACK = 3'd3,
    PH_FWD  = 3'd4,
    PH_DONE = 3'd5
  } phase_e;
endpackage

// File: rtl/beta_ckpt_span.sv
// Geometry of the current sub-block.
module beta_ckpt_span #(
  parameter int LEN_W   = 15,
  parameter int SUB_LOG = 6
) (
  input  logic [LEN_W-1:0]         n_i,
  input  logic [LEN_W-SUB_LOG-1:0] sb_i,
  output logic [LEN_W-1:0]         base_o,
  output logic [LEN_W-1:0]         end_o,
  output logic                     last_o,
  output logic                     next_last_o
);
  localparam int CK_W    = LEN_W - SUB_LOG;
  localparam int SUB_LEN = 1 << SUB_LOG;

  logic [LEN_W-1:0] nm1;
  logic [CK_W-1:0]  last_sb;

  always_comb begin
    nm1         = n_i - 1'b1;
    last_sb     = CK_W'(nm1 >> SUB_LOG);
    base_o      = {sb_i, {SUB_LOG{1'b0}}};
    last_o      = (sb_i == last_sb);
    next_last_o = ((sb_i + 1'b1) == last_sb);
    end_o       = last_o ? n_i : base_o + LEN_W'(SUB_LEN);
  end
endmodule

// File: rtl/beta_ckpt_fsm.sv
module beta_ckpt_fsm
  import beta_ckpt_pkg::*;
#(
  parameter int LEN_W   = 15,
  parameter int SUB_LOG = 6
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     start_i,
  input  logic [LEN_W-1:0]         blk_len_i,
  input  logic [LEN_W-1:0]         base_i,
  input  logic [LEN_W-1:0]         end_i,
  input  logic                     last_i,
  input  logic                     next_last_i,
  output phase_e                   phase_o,
  output logic [LEN_W-1:0]         k_o,
  output logic [LEN_W-1:0]         n_o,
  output logic [LEN_W-SUB_LOG-1:0] sb_o
);
  localparam int CK_W = LEN_W - SUB_LOG;

  phase_e           phase_q, phase_d;
  logic [LEN_W-1:0] k_q, k_d, n_q, n_d;
  logic [CK_W-1:0]  sb_q, sb_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_IDLE;
      k_q     <= '0;
      n_q     <= '0;
      sb_q    <= '0;
    end else begin
      phase_q <= phase_d;
      k_q     <= k_d;
      n_q     <= n_d;
      sb_q    <= sb_d;
    end
  end

  always_comb begin
    phase_d = phase_q;
    k_d     = k_q;
    n_d     = n_q;
    sb_d    = sb_q;
    unique case (phase_q)
      PH_IDLE: begin
        if (start_i && (blk_len_i != '0)) begin
          phase_d = PH_FILL;
          n_d     = blk_len_i;
          k_d     = blk_len_i - 1'b1;
          sb_d    = '0;
        end
      end
      PH_FILL: begin
        if (k_q == '0) begin
          // sb_q is 0 here, so last_i tells whether one sub-block covers N
          if (last_i) begin
            phase_d = PH_BACK;
            k_d     = n_q - 1'b1;
          end else begin
            phase_d = PH_LOAD;
          end
        end else begin
          k_d = k_q - 1'b1;
        end
      end
      PH_LOAD: begin
        phase_d = PH_BACK;
        k_d     = end_i - 1'b1;
      end
      PH_BACK: begin
        if (k_q == base_i) phase_d = PH_FWD;
        else               k_d     = k_q - 1'b1;
      end
      PH_FWD: begin
        if (k_q == end_i - 1'b1) begin
          if (last_i) begin
            phase_d = PH_DONE;
          end else begin
            sb_d = sb_q + 1'b1;
            if (next_last_i) begin
              phase_d = PH_BACK;
              k_d     = n_q - 1'b1;
            end else begin
              phase_d = PH_LOAD;
            end
          end
        end else begin
          k_d = k_q + 1'b1;
        end
      end
      PH_DONE: phase_d = PH_IDLE;
      default: phase_d = PH_IDLE;
    endcase
  end

  assign phase_o = phase_q;
  assign k_o     = k_q;
  assign n_o     = n_q;
  assign sb_o    = sb_q;
endmodule

// File: rtl/beta_ckpt_decode.sv
module beta_ckpt_decode
  import beta_ckpt_pkg::*;
#(
  parameter int LEN_W   = 15,
  parameter int SUB_LOG = 6
) (
  input  phase_e                   phase_i,
  input  logic [LEN_W-1:0]         k_i,
  input  logic [LEN_W-1:0]         n_i,
  input  logic [LEN_W-1:0]         end_i,
  input  logic                     last_i,
  output logic                     busy_o,
  output logic                     done_o,
  output logic                     step_valid_o,
  output logic [LEN_W-1:0]         step_idx_o,
  output logic                     bwd_o,
  output logic                     init_o,
  output logic                     ckpt_wr_o,
  output logic                     ckpt_rd_o,
  output logic [LEN_W-SUB_LOG-1:0] ckpt_addr_o,
  output logic                     lbuf_wr_o,
  output logic                     lbuf_rd_o,
  output logic [SUB_LOG-1:0]       lbuf_addr_o,
  output logic                     out_wr_o
);
  localparam int CK_W = LEN_W - SUB_LOG;

  logic in_fill, in_load, in_back, in_fwd, top_step;

  always_comb begin
    in_fill  = (phase_i == PH_FILL);
    in_load  = (phase_i == PH_LOAD);
    in_back  = (phase_i == PH_BACK);
    in_fwd   = (phase_i == PH_FWD);
    top_step = (k_i == n_i - 1'b1);

    busy_o       = in_fill | in_load | in_back | in_fwd;
    done_o       = (phase_i == PH_DONE);
    step_valid_o = in_fill | in_back | in_fwd;
    bwd_o        = in_fill | in_back;
    step_idx_o   = in_load ? end_i : (step_valid_o ? k_i : '0);

    init_o = (in_fill & top_step) | (in_back & last_i & top_step) |
             (in_fwd & (k_i == '0));

    ckpt_wr_o   = in_fill & (k_i[SUB_LOG-1:0] == '0);
    ckpt_rd_o   = in_load;
    ckpt_addr_o = in_fill ? CK_W'(k_i >> SUB_LOG) :
                  in_load ? CK_W'(end_i >> SUB_LOG) : '0;

    lbuf_wr_o   = in_back;
    lbuf_rd_o   = in_fwd;
    lbuf_addr_o = (in_back | in_fwd) ? k_i[SUB_LOG-1:0] : '0;
    out_wr_o    = in_fwd;
  end
endmodule

// File: rtl/beta_ckpt_seq.sv
module beta_ckpt_seq
  import beta_ckpt_pkg::*;
#(
  parameter int LEN_W   = 15,
  parameter int SUB_LOG = 6
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     start_i,
  input  logic [LEN_W-1:0]         blk_len_i,
  output logic [2:0]               phase_o,
  output logic                     busy_o,
  output logic                     done_o,
  output logic                     step_valid_o,
  output logic [LEN_W-1:0]         step_idx_o,
  output logic                     bwd_o,
  output logic                     init_o,
  output logic                     ckpt_wr_o,
  output logic                     ckpt_rd_o,
  output logic [LEN_W-SUB_LOG-1:0] ckpt_addr_o,
  output logic                     lbuf_wr_o,
  output logic                     lbuf_rd_o,
  output logic [SUB_LOG-1:0]       lbuf_addr_o,
  output logic                     out_wr_o
);
  localparam int CK_W = LEN_W - SUB_LOG;

  phase_e           phase;
  logic [LEN_W-1:0] k, n, base, sb_end;
  logic [CK_W-1:0]  sb;
  logic             last, next_last;

  beta_ckpt_fsm #(.LEN_W(LEN_W), .SUB_LOG(SUB_LOG)) u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .blk_len_i   (blk_len_i),
    .base_i      (base),
    .end_i       (sb_end),
    .last_i      (last),
    .next_last_i (next_last),
    .phase_o     (phase),
    .k_o         (k),
    .n_o         (n),
    .sb_o        (sb)
  );

  beta_ckpt_span #(.LEN_W(LEN_W), .SUB_LOG(SUB_LOG)) u_span (
    .n_i         (n),
    .sb_i        (sb),
    .base_o      (base),
    .end_o       (sb_end),
    .last_o      (last),
    .next_last_o (next_last)
  );

  beta_ckpt_decode #(.LEN_W(LEN_W), .SUB_LOG(SUB_LOG)) u_dec (
    .phase_i      (phase),
    .k_i          (k),
    .n_i          (n),
    .end_i        (sb_end),
    .last_i       (last),
    .busy_o       (busy_o),
    .done_o       (done_o),
    .step_valid_o (step_valid_o),
    .step_idx_o   (step_idx_o),
    .bwd_o        (bwd_o),
    .init_o       (init_o),
    .ckpt_wr_o    (ckpt_wr_o),
    .ckpt_rd_o    (ckpt_rd_o),
    .ckpt_addr_o  (ckpt_addr_o),
    .lbuf_wr_o    (lbuf_wr_o),
    .lbuf_rd_o    (lbuf_rd_o),
    .lbuf_addr_o  (lbuf_addr_o),
    .out_wr_o     (out_wr_o)
  );

  assign phase_o = phase;
endmodule

// File: rtl/beta_ckpt_seq_chk.sv
module beta_ckpt_seq_chk #(
  parameter int LEN_W   = 15,
  parameter int SUB_LOG = 6
) (
  input logic                     clk_i,
  input logic                     rst_ni,
  input logic [2:0]               phase_o,
  input logic                     busy_o,
  input logic                     done_o,
  input logic [LEN_W-1:0]         step_idx_o,
  input logic                     bwd_o,
  input logic                     ckpt_wr_o,
  input logic                     ckpt_rd_o,
  input logic                     lbuf_wr_o,
  input logic                     lbuf_rd_o,
  input logic                     out_wr_o
);
  a_r3_fill_descends: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_o == 3'd1 && $past(phase_o) == 3'd1) |->
      step_idx_o == LEN_W'($past(step_idx_o) - 1'b1));

  a_r4_ckpt_wr_aligned: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ckpt_wr_o |-> (phase_o == 3'd1 && step_idx_o[SUB_LOG-1:0] == '0));

  a_r7_lbuf_wr_backward: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lbuf_wr_o |-> (bwd_o && !out_wr_o));

  a_r8_fwd_ascends: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_o == 3'd4 && $past(phase_o) == 3'd4) |->
      step_idx_o == LEN_W'($past(step_idx_o) + 1'b1));

  a_r8_mem_strobes_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({ckpt_wr_o, ckpt_rd_o, lbuf_wr_o, lbuf_rd_o}));

  a_r9_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  a_r9_done_after_fwd: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> $past(out_wr_o));

  a_r10_busy_not_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(busy_o && done_o));
endmodule

bind beta_ckpt_seq beta_ckpt_seq_chk #(.LEN_W(LEN_W), .SUB_LOG(SUB_LOG)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .phase_o    (phase_o),
  .busy_o     (busy_o),
  .done_o     (done_o),
  .step_idx_o (step_idx_o),
  .bwd_o      (bwd_o),
  .ckpt_wr_o  (ckpt_wr_o),
  .ckpt_rd_o  (ckpt_rd_o),
  .lbuf_wr_o  (lbuf_wr_o),
  .lbuf_rd_o  (lbuf_rd_o),
  .out_wr_o   (out_wr_o)
);

// File: tb/beta_ckpt_seq_test.sv
`timescale 1ns/1ps
module beta_ckpt_seq_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [14:0] blk_len = '0;

  logic [2:0]  phase;
  logic        busy, done, valid, bwd, init, ckwr, ckrd, lbw, lbr, outw;
  logic [14:0] idx;
  logic [8:0]  ckaddr;
  logic [5:0]  laddr;

  int errors = 0;
  int checks = 0;
  int cycles = 0;

  always #5 clk = ~clk;

  beta_ckpt_seq uut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .blk_len_i(blk_len),
    .phase_o(phase), .busy_o(busy), .done_o(done), .step_valid_o(valid),
    .step_idx_o(idx), .bwd_o(bwd), .init_o(init), .ckpt_wr_o(ckwr),
    .ckpt_rd_o(ckrd), .ckpt_addr_o(ckaddr), .lbuf_wr_o(lbw), .lbuf_rd_o(lbr),
    .lbuf_addr_o(laddr), .out_wr_o(outw)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 190000) begin
      errors++;
      $display("FAIL R9: watchdog expired, got no completion exp completion");
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  function automatic logic [42:0] mk(int ph, bit bsy, bit dn, bit vl, bit bw, bit in,
                                     bit cw, bit cr, int ca, bit lw, bit lr, int la,
                                     bit ow, int k);
    return {3'(ph), bsy, dn, vl, bw, in, cw, cr, 9'(ca), lw, lr, 6'(la), ow, 15'(k)};
  endfunction

  task automatic cmp(input logic [42:0] e, input string req);
    logic [42:0] a;
    a = {phase, busy, done, valid, bwd, init, ckwr, ckrd, ckaddr, lbw, lbr, laddr, outw, idx};
    checks++;
    if (a !== e) begin
      errors++;
      $display("FAIL %s: got %h exp %h", req, a, e);
    end
  endtask

  task automatic expect_next(input logic [42:0] e, input string req);
    @(negedge clk);
    cmp(e, req);
  endtask

  task automatic run(input int n, input bit noisy);
    int nsb;
    @(negedge clk);
    blk_len = 15'(n);
    start   = 1'b1;
    // R3, R4: pass 1 backward over all positions
    for (int k = n - 1; k >= 0; k--) begin
      expect_next(mk(1, 1, 0, 1, 1, k == n - 1, (k % 64) == 0, 0, k / 64, 0, 0, 0, 0, k),
                  ((k % 64) == 0) ? "R4 pass1 checkpoint" : "R3 pass1 step");
      start   = noisy;                       // R2: ignored while busy
      blk_len = noisy ? 15'(n + 37) : 15'(n);
    end
    start = 1'b0;
    nsb = (n + 63) / 64;
    for (int j = 0; j < nsb; j++) begin
      int base = 64 * j;
      int len  = (n - base > 64) ? 64 : n - base;
      bit lst  = (j == nsb - 1);
      if (!lst)
        expect_next(mk(2, 1, 0, 0, 0, 0, 0, 1, j + 1, 0, 0, 0, 0, base + 64), "R5 load");
      for (int k = base + len - 1; k >= base; k--)
        expect_next(mk(3, 1, 0, 1, 1, lst && (k == n - 1), 0, 0, 0, 1, 0, k % 64, 0, k),
                    lst ? "R6 R7 last backward" : "R7 backward");
      for (int k = base; k < base + len; k++)
        expect_next(mk(4, 1, 0, 1, 0, k == 0, 0, 0, 0, 0, 1, k % 64, 1, k), "R8 R10 forward");
    end
    expect_next(mk(5, 0, 1, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0), "R9 done");
    expect_next('0, "R9 idle after done");
  endtask

  initial begin
    // R1: reset state
    @(negedge clk);
    cmp('0, "R1 in reset");
    @(negedge clk);
    rst_n = 1'b1;
    expect_next('0, "R1 after reset");

    // R2: zero length start ignored
    @(negedge clk);
    blk_len = '0;
    start   = 1'b1;
    expect_next('0, "R2 zero length");
    start = 1'b0;
    expect_next('0, "R2 zero length hold");

    for (int n = 1; n <= 200; n++) run(n, (n % 3) == 0);
    run(4097, 1'b1);
    run(1000, 1'b0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule